// File: doc/BRIEF.md
# I2S Stereo Receive Channel

This block receives one serial stereo audio stream and turns it into left/right sample pairs that a host can read. It watches the bit clock, the word-select line and the serial data line (all already synchronous to the system clock), shifts each word in MSB first, and stores each completed left/right pair as one entry of a pair-wide receive FIFO. The host reads a pair in two steps: the left sample first, then the right sample. The FIFO entry is released only by the right read.

A small register port is used to set the global, receiver and channel enables, the word length, the data-available trigger level and the interrupt masks. The same port reads back status and holds a flush strobe. A pair that completes while the FIFO is full is discarded whole, and the pairs already stored are kept. The loss sets an overrun flag, which a read of a dedicated clear address removes. One interrupt line combines the status flags that are not masked.

Top module: `i2s_rx_channel`

## Requirements
- R1: Control register at address 0x0 holds global enable (bit 0), receiver enable (bit 1) and channel enable (bit 2), and resets to 0x4. While the global enable is 0 the FIFO is held empty and no pair is stored, whatever the other enables are.
- R2: A pair is stored only while the global, receiver and channel enables are all 1. Clearing the receiver enable or the channel enable stops capture.
- R3: A channel that becomes enabled stores nothing until word select next falls from 1 (right) to 0 (left). The first pair stored is the one whose left word starts at that fall.
- R4: Words arrive MSB first, starting one bit-clock after the word-select change. Bits are sampled on rising bit-clock edges. The first N bits of a word are kept right-justified, so the last kept bit lands in bit 0 and later bits are dropped. A word shorter than N bits gives its full value right-justified. N is set by the code at address 0x1 bits [2:0]: 1=12, 2=16, 3=20, 4=24, 5=32.
- R5: The word-length code resets to 5. Codes 6 and 7 behave as 5. Code 0 stores no pairs.
- R6: A pair that completes while the FIFO holds DEPTH (16) pairs is discarded, the stored pairs keep their contents and order, and the overrun flag (status bit 1) is set.
- R7: Address 0x5 returns the left sample of the oldest pair and address 0x6 the right sample. The FIFO pops only on a right read that follows a left read of the same pair. A right read without a prior left read does not pop. Reads of an empty FIFO return 0. Read data appears one clock after the request.
- R8: Status at address 0x7 shows the fill level in bits [8:4]. Data-available (status bit 0) is 1 when the level is at least the trigger plus 1. The trigger is address 0x2 bits [3:0] and resets to 8.
- R9: A read of address 0x8 returns the overrun flag in bit 0 and clears it.
- R10: Mask register at address 0x3 (bit 0 data-available, bit 1 overrun) resets to 0x3. The irq output is 1 exactly when some status flag is 1 and its mask bit is 0.
- R11: Writing 1 to bit 0 of address 0x4 empties the FIFO when the global or receiver enable is 0. While both are 1 the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial bit clock, synchronous to clk |
| ws_i | input | 1 | Word select, 0 = left, 1 = right |
| sd_i | input | 1 | Serial data |
| host_valid | input | 1 | Register access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid one clock after a read request |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The assertions assume that the bit clock, word select and serial data already arrive synchronized to the system clock. They also assume that each bit-clock level lasts at least one system clock, so that every rising edge is seen exactly once, and that word select and data change only while the bit clock is low. The stimulus generates the serial stream from whole system-clock steps: four cycles low and four cycles high per bit. It changes word select and data only at the start of the low phase. It issues at most one host access per cycle, always with a defined address.

// File: rtl/i2s_rx_pkg.sv
// Shared definitions for the stereo receive channel.
// Assumes: samples are at most SAMPLE_W bits wide.
package i2s_rx_pkg;

    localparam int unsigned SAMPLE_W = 32;

    typedef enum logic [3:0] {
        ADDR_CTRL  = 4'h0,
        ADDR_WLEN  = 4'h1,
        ADDR_TRIG  = 4'h2,
        ADDR_MASK  = 4'h3,
        ADDR_FLUSH = 4'h4,
        ADDR_LEFT  = 4'h5,
        ADDR_RIGHT = 4'h6,
        ADDR_STAT  = 4'h7,
        ADDR_OVCLR = 4'h8
    } reg_addr_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pair_t;

    // Number of bits kept per word for a word-length code; codes above 5 act as 5
    function automatic logic [5:0] wlen_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 6'd0;
            3'd1:    return 6'd12;
            3'd2:    return 6'd16;
            3'd3:    return 6'd20;
            3'd4:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/i2s_rx_deser.sv
// Serial-to-parallel converter for one stereo stream.
// Detects rising bit-clock edges, shifts in data MSB first and closes a word
// at each word-select change (the bit sampled there is the last one of the
// previous word). Emits a one-cycle pair strobe at the end of each right word
// when the pair was armed at the start of its left word.
// Assumes: sck_i, ws_i, sd_i are synchronous to clk, each sck level >= 1 clk.
module i2s_rx_deser
    import i2s_rx_pkg::*;
#(
    parameter int unsigned W = SAMPLE_W,
    localparam int unsigned CNT_W = $clog2(W + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       ws_i,
    input  logic       sd_i,
    input  logic       enable,
    input  logic [2:0] wlen_code,
    output logic       pair_valid,
    output pair_t      pair_data
);

    logic             sck_q;
    logic             ws_q;
    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     left_hold;
    logic             armed;
    logic             left_ok;
    logic             rise;
    logic             take_bit;
    logic [CNT_W-1:0] wlen;
    logic [W-1:0]     final_word;

    // Edge detect and per-word bit budget
    always_comb begin
        rise       = sck_i & ~sck_q;
        wlen       = CNT_W'(wlen_bits(wlen_code));
        take_bit   = cnt < wlen;
        final_word = take_bit ? {shreg[W-2:0], sd_i} : shreg;
    end

    // Shift, word close, arming and pair strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q      <= 1'b0;
            ws_q       <= 1'b0;
            shreg      <= '0;
            cnt        <= '0;
            left_hold  <= '0;
            armed      <= 1'b0;
            left_ok    <= 1'b0;
            pair_valid <= 1'b0;
            pair_data  <= '0;
        end else begin
            sck_q      <= sck_i;
            pair_valid <= 1'b0;
            if (!enable) begin
                armed   <= 1'b0;
                left_ok <= 1'b0;
            end
            if (rise) begin
                ws_q <= ws_i;
                if (ws_i != ws_q) begin
                    shreg <= '0;
                    cnt   <= '0;
                    if (!ws_q) begin
                        left_hold <= final_word;
                        left_ok   <= armed && enable && (wlen != '0);
                    end else begin
                        if (left_ok && armed && enable && (wlen != '0)) begin
                            pair_valid <= 1'b1;
                            pair_data  <= '{left: left_hold, right: final_word};
                        end
                        armed   <= enable;
                        left_ok <= 1'b0;
                    end
                end else if (take_bit) begin
                    shreg <= {shreg[W-2:0], sd_i};
                    cnt   <= cnt + 1'b1;
                end
            end
        end
    end

    // R2
    capture_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(enable));

    // R4
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(W));

endmodule

// File: rtl/i2s_rx_pair_fifo.sv
// Pair-wide receive FIFO. One entry holds a full left/right pair.
// A push into a full FIFO is dropped; a flush empties it and wins over push.
// Assumes: pop is only issued by the register block.
module i2s_rx_pair_fifo
    import i2s_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  pair_t         push_data,
    input  logic          pop,
    output pair_t         head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    pair_t         mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          do_push;
    logic          do_pop;

    // Accept decisions and head output
    always_comb begin
        full    = level == LW'(DEPTH);
        empty   = level == '0;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        head    = empty ? '0 : mem[rptr];
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Pointers and fill level
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    // R6
    drop_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> level == $past(level));

    // R11
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/i2s_rx_regs.sv
// Host register block: enables, word length, trigger, masks, flush strobe,
// two-stage pair read, overrun flag with read-to-clear, interrupt combine.
// Assumes: one access per cycle; read data is registered.
module i2s_rx_regs
    import i2s_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned LW = $clog2(DEPTH + 1),
    localparam int unsigned TRIG_W = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_valid,
    input  logic          host_write,
    input  logic [3:0]    host_addr,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    output logic          irq,
    output logic          rx_enable,
    output logic [2:0]    wlen_code,
    input  logic          pair_push,
    output logic          flush,
    output logic          pop,
    input  pair_t         head,
    input  logic [LW-1:0] level,
    input  logic          full,
    input  logic          empty
);

    logic              glb_en, blk_en, ch_en;
    logic [TRIG_W-1:0] trig;
    logic [1:0]        mask;
    logic              ovr;
    logic              left_seen;
    logic              rd, wr, ovr_set, avail;
    logic              unused_wdata;

    // Access decode, strobes and interrupt combine
    always_comb begin
        rd           = host_valid && !host_write;
        wr           = host_valid && host_write;
        rx_enable    = glb_en && blk_en && ch_en;
        flush        = !glb_en || (wr && host_addr == ADDR_FLUSH && host_wdata[0]
                                   && !(glb_en && blk_en));
        pop          = rd && host_addr == ADDR_RIGHT && left_seen && !empty;
        ovr_set      = pair_push && full;
        avail        = int'(level) >= int'(trig) + 1;
        irq          = (avail && !mask[0]) || (ovr && !mask[1]);
        unused_wdata = ^host_wdata[31:4];
    end

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en    <= 1'b0;
            blk_en    <= 1'b0;
            ch_en     <= 1'b1;
            wlen_code <= 3'd5;
            trig      <= TRIG_W'(8);
            mask      <= 2'b11;
        end else if (wr) begin
            case (host_addr)
                ADDR_CTRL: {ch_en, blk_en, glb_en} <= host_wdata[2:0];
                ADDR_WLEN: wlen_code <= host_wdata[2:0];
                ADDR_TRIG: trig <= host_wdata[TRIG_W-1:0];
                ADDR_MASK: mask <= host_wdata[1:0];
                default:   ;
            endcase
        end
    end

    // Overrun flag (set wins over clear) and left-read tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr       <= 1'b0;
            left_seen <= 1'b0;
        end else begin
            if (ovr_set)                        ovr <= 1'b1;
            else if (rd && host_addr == ADDR_OVCLR) ovr <= 1'b0;
            if (flush || pop)                   left_seen <= 1'b0;
            else if (rd && host_addr == ADDR_LEFT && !empty) left_seen <= 1'b1;
        end
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (rd) begin
            host_rdata <= '0;
            case (host_addr)
                ADDR_CTRL:  host_rdata[2:0] <= {ch_en, blk_en, glb_en};
                ADDR_WLEN:  host_rdata[2:0] <= wlen_code;
                ADDR_TRIG:  host_rdata[TRIG_W-1:0] <= trig;
                ADDR_MASK:  host_rdata[1:0] <= mask;
                ADDR_LEFT:  host_rdata <= head.left;
                ADDR_RIGHT: host_rdata <= head.right;
                ADDR_STAT:  begin
                    host_rdata[1:0]    <= {ovr, avail};
                    host_rdata[4 +: LW] <= level;
                end
                ADDR_OVCLR: host_rdata[0] <= ovr;
                default:    ;
            endcase
        end
    end

    // R7
    pop_after_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level < $past(level)) |->
            ($past(flush) || $past(host_valid && !host_write && host_addr == ADDR_RIGHT)));

    // R9
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && host_addr == ADDR_OVCLR && !ovr_set) |=> !ovr);

    // R1
    glb_off_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> level == '0);

endmodule

// File: rtl/i2s_rx_channel.sv
// Top of the stereo receive channel: deserializer, pair FIFO, register block.
// Assumes: serial inputs already synchronous to clk.
module i2s_rx_channel
    import i2s_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned LW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck_i,
    input  logic        ws_i,
    input  logic        sd_i,
    input  logic        host_valid,
    input  logic        host_write,
    input  logic [3:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        irq
);

    logic          rx_enable;
    logic [2:0]    wlen_code;
    logic          pair_valid;
    pair_t         pair_data;
    logic          flush, pop, full, empty;
    pair_t         head;
    logic [LW-1:0] level;

    i2s_rx_deser i_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck_i),
        .ws_i       (ws_i),
        .sd_i       (sd_i),
        .enable     (rx_enable),
        .wlen_code  (wlen_code),
        .pair_valid (pair_valid),
        .pair_data  (pair_data)
    );

    i2s_rx_pair_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (pair_valid),
        .push_data (pair_data),
        .pop       (pop),
        .head      (head),
        .level     (level),
        .full      (full),
        .empty     (empty)
    );

    i2s_rx_regs #(.DEPTH(DEPTH)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .host_write (host_write),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .irq        (irq),
        .rx_enable  (rx_enable),
        .wlen_code  (wlen_code),
        .pair_push  (pair_valid),
        .flush      (flush),
        .pop        (pop),
        .head       (head),
        .level      (level),
        .full       (full),
        .empty      (empty)
    );

endmodule

// File: tb/test_i2s_rx_channel.sv
module test_i2s_rx_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, ws = 1'b1, sd = 1'b0;
    logic        host_valid = 1'b0, host_write = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic carry = 1'b0;
    bit in_left = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    i2s_rx_channel i_i2s_rx_channel (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
        .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    // code[136:134] slot[133:128] left right exp_left exp_right
    localparam logic [136:0] VEC [7] = '{
        {3'd5, 6'd32, 32'hA5A50F0F, 32'h12345678, 32'hA5A50F0F, 32'h12345678},
        {3'd2, 6'd32, 32'hDEADBEEF, 32'hCAFEF00D, 32'h0000DEAD, 32'h0000CAFE},
        {3'd1, 6'd32, 32'h87654321, 32'hFFFF0001, 32'h00000876, 32'h00000FFF},
        {3'd7, 6'd32, 32'h13579BDF, 32'h2468ACE0, 32'h13579BDF, 32'h2468ACE0},
        {3'd5, 6'd16, 32'h0000ABCD, 32'h00007FFF, 32'h0000ABCD, 32'h00007FFF},
        {3'd4, 6'd24, 32'h00C0FFEE, 32'h00123456, 32'h00C0FFEE, 32'h00123456},
        {3'd3, 6'd32, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'h000F0F0F, 32'h0000F0F0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b0; host_addr = a;
        @(negedge clk);
        host_valid = 1'b0;
        d = host_rdata;
    endtask

    task automatic bit_period(input logic w, input logic d);
        @(negedge clk);
        sck = 1'b0; ws = w; sd = d;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(input logic [31:0] l, input logic [31:0] r, input int slot);
        if (!in_left) bit_period(1'b0, carry);
        for (int i = 1; i < slot; i++) bit_period(1'b0, l[slot-i]);
        bit_period(1'b1, l[0]);
        for (int i = 1; i < slot; i++) bit_period(1'b1, r[slot-i]);
        carry = r[0];
        in_left = 0;
    endtask

    task automatic tail();
        if (!in_left) bit_period(1'b0, carry);
        in_left = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic stat_level(input string req, input int exp);
        rd_reg(4'h7, rv);
        chk(req, {27'b0, rv[8:4]}, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: R1 R5 R8 R10
        rd_reg(4'h0, rv); chk("R1 ctrl reset", rv, 32'h4);
        rd_reg(4'h1, rv); chk("R5 wlen reset", rv, 32'h5);
        rd_reg(4'h2, rv); chk("R8 trig reset", rv, 32'h8);
        rd_reg(4'h3, rv); chk("R10 mask reset", rv, 32'h3);
        rd_reg(4'h7, rv); chk("R8 status reset", rv, 32'h0);
        chk("R10 irq reset", {31'b0, irq}, 32'h0);
        rd_reg(4'h5, rv); chk("R7 empty left read", rv, 32'h0);

        wr_reg(4'h0, 32'h7);
        bit_period(1'b1, 1'b0);
        in_left = 0; carry = 1'b0;

        // Vector table: R4 R5 R7
        for (int k = 0; k < 7; k++) begin
            wr_reg(4'h1, {29'b0, VEC[k][136:134]});
            send_frame(VEC[k][127:96], VEC[k][95:64], int'(VEC[k][133:128]));
            tail();
            rd_reg(4'h5, rv); chk($sformatf("R4 left vec%0d", k), rv, VEC[k][63:32]);
            rd_reg(4'h6, rv); chk($sformatf("R4 right vec%0d", k), rv, VEC[k][31:0]);
            stat_level("R7 popped after pair", 0);
        end
        wr_reg(4'h1, 32'h5);

        // R8 trigger and R10 interrupt
        wr_reg(4'h2, 32'h2);
        send_frame(32'h11111111, 32'h21111111, 32);
        send_frame(32'h12222222, 32'h22222222, 32);
        tail();
        rd_reg(4'h7, rv); chk("R8 level2 no avail", rv, 32'h20);
        send_frame(32'h13333333, 32'h23333333, 32);
        tail();
        rd_reg(4'h7, rv); chk("R8 level3 avail", rv, 32'h31);
        chk("R10 masked irq low", {31'b0, irq}, 32'h0);
        wr_reg(4'h3, 32'h2);
        chk("R10 unmasked avail irq", {31'b0, irq}, 32'h1);
        wr_reg(4'h3, 32'h3);

        // R7 right without left does not pop
        rd_reg(4'h6, rv);
        stat_level("R7 right alone no pop", 3);
        rd_reg(4'h5, rv); chk("R7 left oldest", rv, 32'h11111111);
        rd_reg(4'h6, rv); chk("R7 right oldest", rv, 32'h21111111);
        stat_level("R7 pop after right", 2);

        // R11 flush ignored while enabled, works while disabled
        wr_reg(4'h4, 32'h1);
        stat_level("R11 flush ignored enabled", 2);
        wr_reg(4'h0, 32'h5);
        wr_reg(4'h4, 32'h1);
        stat_level("R11 flush when disabled", 0);

        // R3 enabled mid-left: first pair skipped
        wr_reg(4'h0, 32'h7);
        send_frame(32'hAAAA0001, 32'hBBBB0001, 32);
        send_frame(32'hAAAA0002, 32'hBBBB0002, 32);
        tail();
        stat_level("R3 one pair after enable", 1);
        rd_reg(4'h5, rv); chk("R3 first stored left", rv, 32'hAAAA0002);
        rd_reg(4'h6, rv); chk("R3 first stored right", rv, 32'hBBBB0002);

        // R6 overrun
        wr_reg(4'h2, 32'hF);
        for (int i = 0; i < 16; i++) send_frame(32'h10000000 + i, 32'h20000000 + i, 32);
        tail();
        rd_reg(4'h7, rv); chk("R6 full no overrun", rv, 32'h101);
        send_frame(32'h0BAD0BAD, 32'h0BAD0BAD, 32);
        tail();
        rd_reg(4'h7, rv); chk("R6 overrun set level kept", rv, 32'h103);
        wr_reg(4'h3, 32'h1);
        chk("R10 overrun irq", {31'b0, irq}, 32'h1);
        rd_reg(4'h8, rv); chk("R9 clear read returns flag", rv, 32'h1);
        rd_reg(4'h7, rv); chk("R9 overrun cleared", rv[1:0], 32'h1);
        chk("R10 irq after clear", {31'b0, irq}, 32'h0);
        wr_reg(4'h3, 32'h3);
        for (int i = 0; i < 16; i++) begin
            rd_reg(4'h5, rv); chk("R6 kept left", rv, 32'h10000000 + i);
            rd_reg(4'h6, rv); chk("R6 kept right", rv, 32'h20000000 + i);
        end
        stat_level("R6 dropped pair absent", 0);

        // R5 code 0 stores nothing
        wr_reg(4'h1, 32'h0);
        send_frame(32'h55555555, 32'h66666666, 32);
        tail();
        stat_level("R5 code0 no store", 0);
        wr_reg(4'h1, 32'h5);

        // R2 channel disabled stores nothing
        wr_reg(4'h0, 32'h3);
        send_frame(32'h77777777, 32'h88888888, 32);
        send_frame(32'h77777777, 32'h88888888, 32);
        tail();
        stat_level("R2 channel off no store", 0);

        // R1 global disable flushes and overrides
        wr_reg(4'h0, 32'h7);
        send_frame(32'h99990001, 32'h99990002, 32);
        send_frame(32'h99990003, 32'h99990004, 32);
        tail();
        stat_level("R1 stored before global off", 1);
        wr_reg(4'h0, 32'h6);
        stat_level("R1 global off flushes", 0);
        send_frame(32'h99990005, 32'h99990006, 32);
        tail();
        stat_level("R1 global off no store", 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule